// File: doc/BRIEF.md
# Streaming forward 5/3 integer lifting transform (one dimension)

This block turns a stream of signed samples into 5/3 wavelet coefficients on the fly. A line of samples enters one sample per accepted cycle. The first sample of each line carries a start marker, and the last sample carries an end marker. Samples at even positions of the line act as the low-pass base. Samples at odd positions become high-pass residuals. Every coefficient leaves the block with a valid flag and a tag that says whether it is high-pass or low-pass.

Both lifting steps run through one shared arithmetic path, one step per cycle:

- The predict step subtracts half the sum of the two neighbouring even samples from an odd sample.
- The update step adds a quarter of the sum of two neighbouring residuals, rounded, to an even sample.

All scaling is done by arithmetic shift with floor rounding, so the transform maps integers to integers and can be inverted exactly. Lines are extended symmetrically at both ends. A new line may follow on the very next cycle, because the two closing operations of a line fit into the two slots in which the next line cannot yet produce anything.

Top module: `lift53_fwd`

## Requirements

**Stream format used throughout.** A line has an even length of at least 2. `in_sol` marks position 0, which is even. Later accepted samples alternate odd, even, and so on. `in_eol` is raised only with the last sample of the line, which is at an odd position. Write x[i] for the sample at position i, and M for half the line length.

**Output encoding used throughout.** `out_high`=1 tags a high-pass value d. `out_high`=0 tags a low-pass value s. `out_coef` is two's complement.

**Timing used throughout.** "With the sample" means that the output register takes the value at the same clock edge that accepts the sample.

- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0.
- R2: `out_valid` is 1 only in the cycles named by R3, R4 and R6. In particular:
  - the samples at positions 0 and 1 of a line produce no output;
  - cycles with `in_valid` low produce no output of their own;
  - `in_sol`, `in_eol` and `in_sample` have no effect while `in_valid` is low.
- R3: An even sample x[2k] with k≥1 yields, with the sample, a high-pass value tagged 1:
  - d[k-1] = x[2k-1] - floor((x[2k-2] + x[2k]) / 2).
- R4: An odd sample x[2k+1] with k≥1 yields, with the sample, a low-pass value tagged 0:
  - s[k-1] = x[2k-2] + floor((d[k-2] + d[k-1] + 2) / 4).
- R5: The first low-pass value of a line takes d[-1] equal to d[0]. This is the effect of mirroring x[-1] onto x[1]:
  - s[0] = x[0] + floor((2·d[0] + 2) / 4).
- R6: After the sample that carries `in_eol`, two more values follow, one and two cycles after the one produced with that sample:
  - first, the high-pass value d[M-1] = x[2M-1] - x[2M-2], which mirrors x[2M] onto x[2M-2];
  - then the low-pass value s[M-1].
- R7: A line of length 2 yields exactly d[0] = x[1] - x[0] and then s[0], at the times given in R6.
- R8: A new line may start on the cycle right after `in_eol` with no idle cycle. Both the closing values of the old line and the values of the new line stay as R3 to R6 give them.
- R9: Every output value fits in DATA_W+1 signed bits, so the two top bits of `out_coef` are equal whenever `out_valid` is 1.
- R10: Idle cycles (`in_valid` low) anywhere inside a line leave the values of that line unchanged. They only shift the cycle in which each value appears.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered in this cycle |
| in_sol | input | 1 | Offered sample is position 0 of a line |
| in_eol | input | 1 | Offered sample is the last (odd) position of a line |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | `out_coef` holds a new coefficient |
| out_high | output | 1 | 1 = high-pass value, 0 = low-pass value |
| out_coef | output | DATA_W+2 | Signed coefficient |

## Verification

The assertions check the schedule on every cycle:

- a high-pass value follows each non-initial even sample;
- a low-pass value follows each odd sample after the first pair;
- the closing high-then-low pair comes two and three cycles after the end marker;
- no value appears without one of these causes;
- no coefficient leaves the DATA_W+1-bit range.

Only the bench scenarios can show that the values are correct: the floor rounding of negative sums, the mirrored neighbours at both ends of a line, and the hand-over between back-to-back lines. For these the bench compares against an integer model of the equations, with and without idle gaps.

// File: rtl/lift53_pkg.sv
package lift53_pkg;

  // Operation carried out by the shared lifting path in a cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PRED = 2'd1,
    OP_UPD  = 2'd2
  } lift_op_e;

  // Operand routing for the shared lifting path.
  typedef struct packed {
    lift_op_e op;
    logic     c_mirror;   // predict: right even neighbour is the stored one (line end)
    logic     a_old;      // update: base even sample is the older stored one
    logic     b_dup;      // update: left residual replaced by the current one (line start)
  } lift_ctl_t;

endpackage

// File: rtl/lift53_ctrl.sv
module lift53_ctrl
  import lift53_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      in_sol,
  input  logic      in_eol,
  output lift_ctl_t ctl,
  output logic      ev_wr,
  output logic      od_wr
);

  logic par_odd_q, par_odd_d;   // next accepted sample sits at an odd position
  logic pair0_q,   pair0_d;     // still inside the first sample pair of the line
  logic upd0_q,    upd0_d;      // no low-pass value produced yet in this line
  logic tail1_q,   tail1_d;     // closing predict pending
  logic tail2_q,   tail2_d;     // closing update pending
  logic tfirst_q,  tfirst_d;    // closing update is the first of its line
  logic tshift_q,  tshift_d;    // a new line began during the closing predict

  logic is_even, ev_arr, od_arr, eol_arr, pred_norm, upd_norm;

  always_comb begin
    is_even   = in_sol | ~par_odd_q;
    ev_arr    = in_valid & is_even;
    od_arr    = in_valid & ~is_even;
    eol_arr   = od_arr & in_eol;
    pred_norm = ev_arr & ~in_sol;
    upd_norm  = od_arr & ~pair0_q;

    par_odd_d = par_odd_q;
    if (in_valid) par_odd_d = is_even;

    pair0_d = pair0_q;
    if (ev_arr) pair0_d = in_sol;

    upd0_d = upd0_q;
    if (ev_arr && in_sol)  upd0_d = 1'b1;
    else if (upd_norm)     upd0_d = 1'b0;

    tail1_d  = eol_arr;
    tail2_d  = tail1_q;
    tfirst_d = eol_arr ? pair0_q : tfirst_q;
    tshift_d = tail1_q & ev_arr & in_sol;
  end

  // Operation select: the line-end slots have priority; on a well-formed
  // stream they never coincide with an operation from a new sample.
  always_comb begin
    ctl = '0;
    if (tail1_q) begin
      ctl.op       = OP_PRED;
      ctl.c_mirror = 1'b1;
    end else if (tail2_q) begin
      ctl.op    = OP_UPD;
      ctl.a_old = tshift_q;
      ctl.b_dup = tfirst_q;
    end else if (pred_norm) begin
      ctl.op = OP_PRED;
    end else if (upd_norm) begin
      ctl.op    = OP_UPD;
      ctl.a_old = 1'b1;
      ctl.b_dup = upd0_q;
    end
    ev_wr = ev_arr;
    od_wr = od_arr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_odd_q <= 1'b0;
      pair0_q   <= 1'b1;
      upd0_q    <= 1'b1;
      tail1_q   <= 1'b0;
      tail2_q   <= 1'b0;
      tfirst_q  <= 1'b0;
      tshift_q  <= 1'b0;
    end else begin
      par_odd_q <= par_odd_d;
      pair0_q   <= pair0_d;
      upd0_q    <= upd0_d;
      tail1_q   <= tail1_d;
      tail2_q   <= tail2_d;
      tfirst_q  <= tfirst_d;
      tshift_q  <= tshift_d;
    end
  end

endmodule

// File: rtl/lift53_store.sv
module lift53_store
  import lift53_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  lift_ctl_t                ctl,
  input  logic                     ev_wr,
  input  logic                     od_wr,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic signed [COEF_W-1:0] res,
  output logic signed [COEF_W-1:0] opa,
  output logic signed [COEF_W-1:0] opb,
  output logic signed [COEF_W-1:0] opc
);

  localparam int EXT_W = COEF_W - DATA_W;

  logic signed [DATA_W-1:0] ev0_q, ev0_d, ev1_q, ev1_d, od_q, od_d;
  logic signed [COEF_W-1:0] dq0_q, dq0_d, dq1_q, dq1_d;
  logic                     dq_wr;

  function automatic logic signed [COEF_W-1:0] widen(input logic signed [DATA_W-1:0] v);
    return {{EXT_W{v[DATA_W-1]}}, v};
  endfunction

  // Next state with explicit enables.
  always_comb begin
    dq_wr = (ctl.op == OP_PRED);
    ev0_d = ev0_q;
    ev1_d = ev1_q;
    od_d  = od_q;
    dq0_d = dq0_q;
    dq1_d = dq1_q;
    if (ev_wr) begin
      ev1_d = ev0_q;
      ev0_d = in_sample;
    end
    if (od_wr) od_d = in_sample;
    if (dq_wr) begin
      dq1_d = dq0_q;
      dq0_d = res;
    end
  end

  // Operand routing into the shared path.
  always_comb begin
    opa = '0;
    opb = '0;
    opc = '0;
    case (ctl.op)
      OP_PRED: begin
        opa = widen(od_q);
        opb = widen(ev0_q);
        opc = ctl.c_mirror ? widen(ev0_q) : widen(in_sample);
      end
      OP_UPD: begin
        opa = ctl.a_old ? widen(ev1_q) : widen(ev0_q);
        opb = ctl.b_dup ? dq0_q : dq1_q;
        opc = dq0_q;
      end
      default: begin
        opa = '0;
        opb = '0;
        opc = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev0_q <= '0;
      ev1_q <= '0;
      od_q  <= '0;
      dq0_q <= '0;
      dq1_q <= '0;
    end else begin
      ev0_q <= ev0_d;
      ev1_q <= ev1_d;
      od_q  <= od_d;
      dq0_q <= dq0_d;
      dq1_q <= dq1_d;
    end
  end

endmodule

// File: rtl/lift53_alu.sv
module lift53_alu #(
  parameter int COEF_W = 10
) (
  input  logic                     pred,
  input  logic signed [COEF_W-1:0] opa,
  input  logic signed [COEF_W-1:0] opb,
  input  logic signed [COEF_W-1:0] opc,
  output logic signed [COEF_W-1:0] res
);

  localparam int SUM_W = COEF_W + 1;

  logic signed [SUM_W-1:0] bias, pair_sum, scaled;

  // Shared path: neighbour sum, one shift select, then add or subtract.
  always_comb begin
    bias     = pred ? SUM_W'(0) : SUM_W'(2);
    pair_sum = SUM_W'(opb) + SUM_W'(opc) + bias;
    scaled   = pred ? (pair_sum >>> 1) : (pair_sum >>> 2);
    res      = pred ? (opa - scaled[COEF_W-1:0]) : (opa + scaled[COEF_W-1:0]);
  end

endmodule

// File: rtl/lift53_fwd.sv
module lift53_fwd
  import lift53_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sol,
  input  logic                     in_eol,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic                     out_high,
  output logic signed [DATA_W+1:0] out_coef
);

  localparam int COEF_W = DATA_W + 2;

  lift_ctl_t                ctl;
  logic                     ev_wr, od_wr;
  logic signed [COEF_W-1:0] opa, opb, opc, res;

  logic                     ov_q, ov_d, oh_q, oh_d;
  logic signed [COEF_W-1:0] oc_q, oc_d;

  lift53_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sol   (in_sol),
    .in_eol   (in_eol),
    .ctl      (ctl),
    .ev_wr    (ev_wr),
    .od_wr    (od_wr)
  );

  lift53_store #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .ev_wr     (ev_wr),
    .od_wr     (od_wr),
    .in_sample (in_sample),
    .res       (res),
    .opa       (opa),
    .opb       (opb),
    .opc       (opc)
  );

  lift53_alu #(
    .COEF_W (COEF_W)
  ) i_alu (
    .pred (ctl.op == OP_PRED),
    .opa  (opa),
    .opb  (opb),
    .opc  (opc),
    .res  (res)
  );

  // Output register; the coefficient only loads when a result is produced.
  always_comb begin
    ov_d = (ctl.op != OP_IDLE);
    oh_d = (ctl.op == OP_PRED);
    oc_d = ov_d ? res : oc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      oh_q <= 1'b0;
      oc_q <= '0;
    end else begin
      ov_q <= ov_d;
      oh_q <= oh_d;
      oc_q <= oc_d;
    end
  end

  assign out_valid = ov_q;
  assign out_high  = oh_q;
  assign out_coef  = oc_q;

endmodule

// File: rtl/lift53_chk.sv
module lift53_chk #(
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_sol,
  input logic                     in_eol,
  input logic                     out_valid,
  input logic                     out_high,
  input logic signed [DATA_W+1:0] out_coef
);

  // Independent position tracking of the input stream.
  logic c_odd_q, c_first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_odd_q   <= 1'b0;
      c_first_q <= 1'b1;
    end else if (in_valid) begin
      c_odd_q <= in_sol | ~c_odd_q;
      if (in_sol | ~c_odd_q) c_first_q <= in_sol;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_pred_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sol && !c_odd_q) |=> (out_valid && out_high));

  p_upd_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sol && c_odd_q && !c_first_q) |=> (out_valid && !out_high));

  p_tail_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sol && c_odd_q && in_eol) |-> ##2 (out_valid && out_high));

  p_tail_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sol && c_odd_q && in_eol) |-> ##3 (out_valid && !out_high));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) || $past(in_valid && in_eol, 2) || $past(in_valid && in_eol, 3)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_coef[DATA_W+1] == out_coef[DATA_W]));

endmodule

bind lift53_fwd lift53_chk #(.DATA_W(DATA_W)) i_lift53_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sol    (in_sol),
  .in_eol    (in_eol),
  .out_valid (out_valid),
  .out_high  (out_high),
  .out_coef  (out_coef)
);

// File: tb/test_lift53_fwd.sv
module test_lift53_fwd;

  localparam int DW = 8;
  localparam int CW = DW + 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_sol = 1'b0;
  logic                 in_eol = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic                 out_valid, out_high;
  logic signed [CW-1:0] out_coef;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  int    due_q[$];
  int    val_q[$];
  bit    hi_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  lift53_fwd #(.DATA_W(DW)) i_lift53_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_eol    (in_eol),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_high  (out_high),
    .out_coef  (out_coef)
  );

  task automatic expect_out(input int due, input bit hi, input int val, input string tag);
    due_q.push_back(due);
    hi_q.push_back(hi);
    val_q.push_back(val);
    tag_q.push_back(tag);
  endtask

  // Per-cycle comparison, 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #2;
      if (rst_n) begin
        n_chk++;
        if (due_q.size() != 0 && due_q[0] == cyc) begin
          if (!out_valid || out_high !== hi_q[0] || int'(out_coef) != val_q[0]) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual valid=%0b high=%0b coef=%0d expected valid=1 high=%0b coef=%0d",
                     tag_q[0], cyc, out_valid, out_high, int'(out_coef), hi_q[0], val_q[0]);
          end
          void'(due_q.pop_front());
          void'(hi_q.pop_front());
          void'(val_q.pop_front());
          void'(tag_q.pop_front());
        end else if (out_valid !== 1'b0) begin
          n_bad++;
          $display("FAIL R2 cycle %0d: actual valid=%0b expected valid=0", cyc, out_valid);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sol    = 1'($urandom);
      in_eol    = 1'($urandom);
      in_sample = DW'($urandom);
    end
  endtask

  // Drives one line and queues the values the equations give, with their cycles.
  task automatic send_line(input int xs[], input string ltag, input int gap_pct);
    int len;
    int m;
    int d[];
    int s[];
    len = xs.size();
    m   = len / 2;
    d   = new[m];
    s   = new[m];
    for (int n = 0; n < m; n++) begin
      int xr;
      xr   = (2*n + 2 < len) ? xs[2*n + 2] : xs[2*n];
      d[n] = xs[2*n + 1] - ((xs[2*n] + xr) >>> 1);
    end
    for (int n = 0; n < m; n++) begin
      int dl;
      dl   = (n == 0) ? d[0] : d[n - 1];
      s[n] = xs[2*n] + ((dl + d[n] + 2) >>> 2);
    end
    for (int i = 0; i < len; i++) begin
      if (i != 0) begin
        while (gap_pct > 0 && $urandom_range(99) < gap_pct) idle(1);
      end
      @(negedge clk);
      in_valid  = 1'b1;
      in_sol    = (i == 0);
      in_eol    = (i == len - 1);
      in_sample = DW'(xs[i]);
      if (i % 2 == 0 && i >= 2)
        expect_out(cyc + 1, 1'b1, d[i/2 - 1], {"R3/", ltag});
      if (i % 2 == 1 && i >= 3)
        expect_out(cyc + 1, 1'b0, s[(i-3)/2], {((i-3)/2 == 0) ? "R5/" : "R4/", ltag});
      if (i == len - 1) begin
        expect_out(cyc + 2, 1'b1, d[m - 1], {"R6/", ltag});
        expect_out(cyc + 3, 1'b0, s[m - 1], {(m == 1) ? "R5/R6/" : "R6/", ltag});
      end
    end
  endtask

  task automatic rand_line(input int len, input string ltag, input int gap_pct);
    int xs[];
    xs = new[len];
    for (int i = 0; i < len; i++) xs[i] = int'($urandom_range(255)) - 128;
    send_line(xs, ltag, gap_pct);
  endtask

  // Watchdog: a hung run is a failed check and still reports.
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual=still running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int xa[];
    // R1: quiet during and right after reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 in reset: actual valid=%0b expected valid=0", out_valid);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 after release: actual valid=%0b expected valid=0", out_valid);
    end
    idle(3);

    // R3 R4 R5 R6: fixed line with negative sums, contiguous
    xa = '{10, -3, 25, 7, -60, 90, 127, -128};
    send_line(xa, "R3", 0);
    idle(4);

    // R7: shortest line
    xa = '{5, -9};
    send_line(xa, "R7", 0);
    idle(4);
    xa = '{-7, 100};
    send_line(xa, "R7", 0);
    idle(4);

    // R8: back-to-back lines with no idle cycle in between
    rand_line(2, "R8", 0);
    rand_line(4, "R8", 0);
    rand_line(2, "R8", 0);
    rand_line(6, "R8", 0);
    rand_line(2, "R8", 0);
    idle(4);

    // R9: extreme alternating values
    xa = new[10];
    for (int i = 0; i < 10; i++) xa[i] = (i % 2 == 0) ? 127 : -128;
    send_line(xa, "R9", 0);
    for (int i = 0; i < 10; i++) xa[i] = (i % 2 == 0) ? -128 : 127;
    send_line(xa, "R9", 0);
    idle(4);

    // R10: idle gaps inside lines, junk on the control inputs while idle
    for (int l = 0; l < 8; l++) rand_line(2 * int'($urandom_range(1, 8)), "R10", 40);
    idle(4);

    // Random lines of random even length with occasional gaps
    for (int l = 0; l < 40; l++) rand_line(2 * int'($urandom_range(1, 8)), "R4", 10);
    idle(10);

    n_chk++;
    if (due_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 end of run: actual pending=%0d expected pending=0", due_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule